// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the protocol core of a slave on a two-wire serial bus that fronts a 128-byte memory. A front end, not part of this block, turns the bus wires into single-cycle events: start, stop, a clock rising edge with the sampled data level, and a clock falling edge. The engine decodes the first byte of each transfer as an addressing byte. It acknowledges that byte only when the byte carries the fixed device code and the three select bits match the strap inputs. After that it takes a word address, accepts data bytes for a write, or shifts memory bytes out for a read.

The engine drives the data line through a single open-drain enable, where 1 means pull low. Write bytes leave on a strobe toward an external page buffer, and a commit pulse on the closing stop starts the external write timer. While that timer reports busy, the engine acknowledges nothing. A master can therefore poll with a write addressing byte until the engine acknowledges again.

Top module: `tw_eeprom_engine`

## Requirements
- R1: An addressing byte is acknowledged only if bits 7:4 equal 1010 and bits 3:1 equal `sel_pins[2:0]`. The acknowledge is `sda_oe`=1 from the clock fall after the 8th bit until the clock fall after the 9th rise. On a mismatch, `sda_oe` stays 0 until the next start.
- R2: Bit 0 of the addressing byte selects the direction: 1 is a read and 0 is a write.
- R3: While `busy` is 1, no byte is acknowledged, including a matching addressing byte. When `busy` returns to 0, a matching addressing byte is acknowledged again.
- R4: In a write, the byte after the addressing byte loads the 7-bit pointer (`rd_addr`) from its bits 6:0. Bit 7 is ignored. The byte is acknowledged.
- R5: Every later write byte gives a one-cycle `wr_en` with `wr_addr` equal to the pointer and `wr_data` equal to the byte. It is acknowledged.
- R6: After each write byte, pointer bits 3:0 increment and wrap within the 16-byte page. Bits 6:4 keep their value.
- R7: A stop at a byte boundary after at least one whole write byte gives a one-cycle `wr_commit`. A start or stop in the middle of a byte aborts the transfer with no commit.
- R8: In a read, the byte at the pointer goes out MSB first, with `sda_oe` equal to the inverted bit. `sda_oe` changes only on a clock fall, start or stop. The pointer increments after each byte and wraps from 127 to 0.
- R9: When the master leaves the 9th bit of a read byte high (no acknowledge), `sda_oe` stays 0 until the next start.
- R10: After reset, `sda_oe`, `wr_en` and `wr_commit` are 0 and the pointer is 0.
- R11: A stop after an unmatched addressing byte leaves the pointer unchanged and gives no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | One-cycle start condition event |
| stop_evt | input | 1 | One-cycle stop condition event |
| scl_rise | input | 1 | One-cycle serial clock rising event; `sda_in` is sampled with it |
| scl_fall | input | 1 | One-cycle serial clock falling event |
| sda_in | input | 1 | Sampled data line level |
| sel_pins | input | 3 | Strapped select levels |
| busy | input | 1 | External write cycle in progress |
| rd_data | input | 8 | Memory byte at `rd_addr` |
| rd_addr | output | 7 | Address pointer |
| sda_oe | output | 1 | Open-drain pull-low enable for the data line |
| wr_en | output | 1 | Write byte strobe to the page buffer |
| wr_addr | output | 7 | Address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | Starts the external write cycle |

## Verification
The address decoder is tried with a matching byte and with bytes that differ only in the select bits or only in the code. This separates a full compare from a partial one. Writes start at a mid-page address with bit 7 set, and at an address two bytes below a page end. These show whether the top pointer bit is masked and whether page wrapping leaves the upper bits alone. Reads start near the top of the array and end with a no-acknowledge, which separates array wrapping from page wrapping and shows whether the line is released. Stops and starts placed inside a byte, and addressing bytes sent while `busy` is high, tell an abort or a suppressed acknowledge apart from a normal ending.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_WDATA,
      ST_RDATA
   } tw_state_e;
endpackage

// File: rtl/tw_ctrl_match.sv
module tw_ctrl_match #(
   parameter int DW     = 8,
   parameter int SEL_W  = 3,
   parameter int CODE_W = 4,
   parameter logic [CODE_W-1:0] CODE = 4'b1010
) (
   input  logic [DW-1:0]    ctrl_byte,
   input  logic [SEL_W-1:0] straps,
   output logic             hit,
   output logic             is_read
);
   always_comb begin
      hit     = (ctrl_byte[DW-1 -: CODE_W] == CODE) && (ctrl_byte[SEL_W:1] == straps);
      is_read = ctrl_byte[0];
   end
endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
   parameter int AW     = 7,
   parameter int PAGE_W = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc_page,
   input  logic          inc_all,
   output logic [AW-1:0] ptr
);
   logic [AW-1:0] ptr_q;
   logic [AW-1:0] page_next;
   logic [AW-1:0] all_next;

   assign all_next = ptr_q + 1'b1;

   generate
      if (PAGE_W >= AW) begin : g_flat
         assign page_next = all_next;
      end else begin : g_paged
         assign page_next = {ptr_q[AW-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load) begin
         ptr_q <= load_val;
      end else if (inc_page) begin
         ptr_q <= page_next;
      end else if (inc_all) begin
         ptr_q <= all_next;
      end
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/tw_tx_shift.sv
module tw_tx_shift #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          shift,
   output logic          msb
);
   logic [DW-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= load_val;
      end else if (shift) begin
         sr_q <= {sr_q[DW-2:0], 1'b0};
      end
   end

   assign msb = sr_q[DW-1];
endmodule

// File: rtl/tw_eeprom_engine.sv
module tw_eeprom_engine
   import tw_eeprom_pkg::*;
#(
   parameter int AW     = 7,
   parameter int DW     = 8,
   parameter int PAGE_W = 4,
   parameter int SEL_W  = 3,
   parameter int CODE_W = 4,
   parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_evt,
   input  logic             stop_evt,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_in,
   input  logic [SEL_W-1:0] sel_pins,
   input  logic             busy,
   input  logic [DW-1:0]    rd_data,
   output logic [AW-1:0]    rd_addr,
   output logic             sda_oe,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [DW-1:0]    wr_data,
   output logic             wr_commit
);
   localparam int CNT_W = $clog2(DW + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DW);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("byte width must be 8");
      end
      if (CODE_W + SEL_W + 1 != DW) begin : g_bad_split
         $error("code, select and direction bits must fill one byte");
      end
      if (AW >= DW || PAGE_W > AW || PAGE_W < 1) begin : g_bad_addr
         $error("address or page width out of range");
      end
   endgenerate

   tw_state_e        state_q, nxt_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DW-2:0]    shr_q;
   logic             ack_go_q, got_data_q, sda_oe_q;
   logic             wr_en_q, commit_q;
   logic [AW-1:0]    wr_addr_q;
   logic [DW-1:0]    wr_data_q;

   logic [DW-1:0]    rx_byte;
   logic             receiving, last_rx, read_last, ack_rise;
   logic             ctrl_hit, ctrl_rd;
   logic             ptr_load, ptr_page, ptr_all;
   logic             tx_load, tx_shift, tx_msb;
   logic [AW-1:0]    ptr;

   assign rx_byte   = {shr_q, sda_in};
   assign receiving = (state_q == ST_CTRL) || (state_q == ST_ADDR) || (state_q == ST_WDATA);
   assign last_rx   = scl_rise && receiving && (cnt_q == LAST_BIT);
   assign read_last = scl_rise && (state_q == ST_RDATA) && (cnt_q == LAST_BIT);
   assign ack_rise  = scl_rise && (state_q != ST_IDLE) && (cnt_q == ACK_SLOT);

   tw_ctrl_match #(.DW(DW), .SEL_W(SEL_W), .CODE_W(CODE_W), .CODE(DEV_CODE)) u_match (
      .ctrl_byte (rx_byte),
      .straps    (sel_pins),
      .hit       (ctrl_hit),
      .is_read   (ctrl_rd)
   );

   assign ptr_load = last_rx && (state_q == ST_ADDR);
   assign ptr_page = last_rx && (state_q == ST_WDATA) && !busy;
   assign ptr_all  = read_last;

   tw_addr_ptr #(.AW(AW), .PAGE_W(PAGE_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load && !start_evt && !stop_evt),
      .load_val (rx_byte[AW-1:0]),
      .inc_page (ptr_page && !start_evt && !stop_evt),
      .inc_all  (ptr_all && !start_evt && !stop_evt),
      .ptr      (ptr)
   );

   assign tx_load  = ack_rise && !start_evt && !stop_evt &&
                     (((state_q == ST_CTRL) && ack_go_q && (nxt_q == ST_RDATA)) ||
                      ((state_q == ST_RDATA) && !sda_in));
   assign tx_shift = scl_rise && (state_q == ST_RDATA) && (cnt_q < ACK_SLOT);

   tw_tx_shift #(.DW(DW)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tx_load),
      .load_val (rd_data),
      .shift    (tx_shift),
      .msb      (tx_msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         nxt_q      <= ST_IDLE;
         cnt_q      <= '0;
         shr_q      <= '0;
         ack_go_q   <= 1'b0;
         got_data_q <= 1'b0;
         sda_oe_q   <= 1'b0;
         wr_en_q    <= 1'b0;
         commit_q   <= 1'b0;
         wr_addr_q  <= '0;
         wr_data_q  <= '0;
      end else begin
         wr_en_q  <= 1'b0;
         commit_q <= 1'b0;
         if (start_evt) begin
            state_q    <= ST_CTRL;
            cnt_q      <= '0;
            sda_oe_q   <= 1'b0;
            ack_go_q   <= 1'b0;
            got_data_q <= 1'b0;
         end else if (stop_evt) begin
            commit_q <= (state_q == ST_WDATA) && (cnt_q == '0) && got_data_q;
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sda_oe_q <= 1'b0;
         end else begin
            if (scl_rise && state_q != ST_IDLE) begin
               if (cnt_q < ACK_SLOT) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (receiving) begin
                     shr_q <= rx_byte[DW-2:0];
                  end
                  if (last_rx) begin
                     unique case (state_q)
                        ST_CTRL: begin
                           ack_go_q <= ctrl_hit && !busy;
                           nxt_q    <= ctrl_rd ? ST_RDATA : ST_ADDR;
                        end
                        ST_ADDR: begin
                           ack_go_q <= !busy;
                           nxt_q    <= ST_WDATA;
                        end
                        default: begin
                           ack_go_q <= !busy;
                           nxt_q    <= ST_WDATA;
                           if (!busy) begin
                              wr_en_q    <= 1'b1;
                              wr_addr_q  <= ptr;
                              wr_data_q  <= rx_byte;
                              got_data_q <= 1'b1;
                           end
                        end
                     endcase
                  end
               end else begin
                  cnt_q <= '0;
                  if (state_q == ST_RDATA) begin
                     state_q <= sda_in ? ST_IDLE : ST_RDATA;
                  end else begin
                     state_q <= ack_go_q ? nxt_q : ST_IDLE;
                  end
               end
            end
            if (scl_fall) begin
               if (state_q == ST_RDATA) begin
                  sda_oe_q <= (cnt_q < ACK_SLOT) ? !tx_msb : 1'b0;
               end else if (receiving && cnt_q == ACK_SLOT) begin
                  sda_oe_q <= ack_go_q && !busy;
               end else begin
                  sda_oe_q <= 1'b0;
               end
            end
         end
      end
   end

   assign rd_addr   = ptr;
   assign sda_oe    = sda_oe_q;
   assign wr_en     = wr_en_q;
   assign wr_addr   = wr_addr_q;
   assign wr_data   = wr_data_q;
   assign wr_commit = commit_q;
endmodule

// File: rtl/tw_eeprom_engine_chk.sv
module tw_eeprom_engine_chk
   import tw_eeprom_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int DW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_evt,
   input logic             stop_evt,
   input logic             scl_rise,
   input logic             scl_fall,
   input logic             sda_in,
   input logic             busy,
   input logic             sda_oe,
   input logic             wr_en,
   input logic             wr_commit,
   input tw_state_e        state_q,
   input logic [CNT_W-1:0] cnt_q
);
   // R8: the data line enable moves only on a clock fall or a bus condition
   a_r8_sda_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_fall && !start_evt && !stop_evt) |=> $stable(sda_oe));

   // R3: an acknowledge never begins when busy was seen at the driving fall
   a_r3_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && state_q != ST_RDATA) |-> !$past(busy));

   // R7: a commit only follows a stop
   a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(stop_evt));

   // R5: each write strobe lasts one cycle
   a_r5_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R9: master no-acknowledge ends the read
   a_r9_nack_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_rise && sda_in && state_q == ST_RDATA && cnt_q == CNT_W'(DW) &&
       !start_evt && !stop_evt) |=> state_q == ST_IDLE);

   // R1: while not addressed the line is released
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !sda_oe);
endmodule

bind tw_eeprom_engine tw_eeprom_engine_chk #(.CNT_W(CNT_W), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_evt (start_evt),
   .stop_evt  (stop_evt),
   .scl_rise  (scl_rise),
   .scl_fall  (scl_fall),
   .sda_in    (sda_in),
   .busy      (busy),
   .sda_oe    (sda_oe),
   .wr_en     (wr_en),
   .wr_commit (wr_commit),
   .state_q   (state_q),
   .cnt_q     (cnt_q)
);

// File: tb/tw_eeprom_engine_tb.sv
`timescale 1ns/100ps
module tw_eeprom_engine_tb;
   localparam int M_IDLE = 0, M_CTRL = 1, M_ADDR = 2, M_WDATA = 3, M_RDATA = 4;
   localparam logic [2:0] STRAP = 3'b101;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_evt = 0, stop_evt = 0, scl_rise = 0, scl_fall = 0, sda_in = 1;
   logic [2:0] sel_pins = STRAP;
   logic       busy = 0;
   logic [7:0] rd_data;
   logic [6:0] rd_addr, wr_addr;
   logic       sda_oe, wr_en, wr_commit;
   logic [7:0] wr_data;
   logic [7:0] mem [128];

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R10";
   bit    done = 0;

   // reference model state
   int         mstate = M_IDLE;
   bit         mrd = 0, mgot = 0, mmid = 0;
   logic [6:0] mptr = '0;
   bit         exp_sda = 0, exp_wr = 0, exp_commit = 0;
   logic [6:0] exp_waddr = '0;
   logic [7:0] exp_wdata = '0;

   always #2.5 clk = ~clk;

   assign rd_data = mem[rd_addr];

   tw_eeprom_engine u_dut (
      .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .sel_pins(sel_pins),
      .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr), .sda_oe(sda_oe),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({cur_req, " sda_oe"}, sda_oe, exp_sda);
         chk({cur_req, " wr_en"}, wr_en, exp_wr);
         chk({cur_req, " wr_commit"}, wr_commit, exp_commit);
         chk({cur_req, " pointer"}, rd_addr, mptr);
         if (exp_wr) begin
            chk({cur_req, " wr_addr"}, wr_addr, exp_waddr);
            chk({cur_req, " wr_data"}, wr_data, exp_wdata);
         end
      end
   end

   task automatic step(input bit s, input bit f, input bit r, input bit p, input bit d);
      @(negedge clk);
      start_evt = s; scl_fall = f; scl_rise = r; stop_evt = p; sda_in = d;
      @(posedge clk); #1;
      start_evt = 0; scl_fall = 0; scl_rise = 0; stop_evt = 0;
      exp_wr = 0; exp_commit = 0;
   endtask

   task automatic m_start();
      step(1, 0, 0, 0, 1);
      mstate = M_CTRL; mgot = 0; mmid = 0; exp_sda = 0;
      step(0, 1, 0, 0, 1);
      exp_sda = 0;
   endtask

   task automatic m_stop();
      step(0, 0, 0, 1, 1);
      if (mstate == M_WDATA && !mmid && mgot) exp_commit = 1;
      mstate = M_IDLE; mmid = 0; exp_sda = 0;
   endtask

   task automatic m_bits(input int n, input logic [7:0] b);
      for (int i = 7; i > 7 - n; i--) begin
         step(0, 0, 1, 0, b[i]);
         step(0, 1, 0, 0, b[i]);
      end
      mmid = 1;
   endtask

   task automatic m_wbyte(input logic [7:0] b, output bit got_ack);
      bit a = 0;
      got_ack = 0;
      for (int i = 7; i >= 0; i--) begin
         step(0, 0, 1, 0, b[i]);
         mmid = 1;
         if (i == 0) begin
            case (mstate)
               M_CTRL:  begin a = (b[7:4] == 4'hA) && (b[3:1] == sel_pins) && !busy; mrd = b[0]; end
               M_ADDR:  begin a = !busy; mptr = b[6:0]; end
               M_WDATA: begin
                  a = !busy;
                  if (!busy) begin
                     exp_wr = 1; exp_waddr = mptr; exp_wdata = b; mgot = 1;
                     mptr = {mptr[6:4], mptr[3:0] + 4'd1};
                  end
               end
               default: a = 0;
            endcase
         end
         step(0, 1, 0, 0, b[i]);
         exp_sda = (i == 0) ? a : 1'b0;
         if (i == 0) got_ack = sda_oe;
      end
      step(0, 0, 1, 0, 1);
      mmid = 0;
      if (mstate != M_IDLE) begin
         if (!a) mstate = M_IDLE;
         else if (mstate == M_CTRL) mstate = mrd ? M_RDATA : M_ADDR;
         else mstate = M_WDATA;
      end
      step(0, 1, 0, 0, 1);
      exp_sda = (mstate == M_RDATA) ? ~mem[mptr][7] : 1'b0;
   endtask

   task automatic m_rbyte(input bit mack, output logic [7:0] got);
      logic [7:0] v;
      v = mem[mptr];
      for (int i = 7; i >= 0; i--) begin
         got[i] = ~sda_oe;
         step(0, 0, 1, 0, ~sda_oe);
         if (i == 0) mptr = mptr + 7'd1;
         step(0, 1, 0, 0, 1);
         exp_sda = (i > 0) ? ~v[i-1] : 1'b0;
      end
      step(0, 0, 1, 0, ~mack);
      if (!mack) mstate = M_IDLE;
      step(0, 1, 0, 0, 1);
      exp_sda = mack ? ~mem[mptr][7] : 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit         ack;
      logic [7:0] rb;
      for (int i = 0; i < 128; i++) mem[i] = 8'(i * 29 + 7);
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 sda_oe", sda_oe, 0);
      chk("R10 pointer", rd_addr, 0);
      chk("R10 wr_en", wr_en, 0);
      chk("R10 wr_commit", wr_commit, 0);
      rst_n = 1;
      @(negedge clk);

      // R1 R2 R4 R5 R7: matching write, address with bit 7 set, three bytes, commit
      cur_req = "R1";
      m_start();
      m_wbyte({4'hA, STRAP, 1'b0}, ack); chk("R1 match ack", ack, 1);
      cur_req = "R4";
      m_wbyte(8'hC5, ack); chk("R4 addr ack", ack, 1);
      chk("R4 bit7 ignored", rd_addr, 7'h45);
      cur_req = "R5";
      m_wbyte(8'h11, ack); chk("R5 data ack", ack, 1);
      m_wbyte(8'h22, ack);
      m_wbyte(8'h33, ack);
      cur_req = "R7";
      m_stop();
      chk("R7 commit pulse", wr_commit, 1);

      // R6: page wrap
      cur_req = "R6";
      m_start();
      m_wbyte({4'hA, STRAP, 1'b0}, ack);
      m_wbyte(8'h5E, ack);
      for (int k = 0; k < 4; k++) m_wbyte(8'(8'h80 + k), ack);
      chk("R6 page wrap pointer", rd_addr, 7'h52);
      m_stop();

      // R3: busy suppresses ack, polling recovers
      cur_req = "R3";
      busy = 1;
      m_start();
      m_wbyte({4'hA, STRAP, 1'b0}, ack); chk("R3 busy no ack", ack, 0);
      m_wbyte(8'h10, ack); chk("R3 busy addr ignored", ack, 0);
      m_stop();
      chk("R3 no commit", wr_commit, 0);
      busy = 0;
      m_start();
      m_wbyte({4'hA, STRAP, 1'b0}, ack); chk("R3 poll ack", ack, 1);
      m_stop();

      // R1 R11: mismatches in select bits and code
      cur_req = "R11";
      m_start();
      m_wbyte({4'hA, 3'b100, 1'b0}, ack); chk("R1 select mismatch", ack, 0);
      m_wbyte(8'h01, ack); chk("R1 later byte ignored", ack, 0);
      m_wbyte(8'h77, ack);
      m_stop();
      chk("R11 no commit", wr_commit, 0);
      chk("R11 pointer kept", rd_addr, 7'h52);
      m_start();
      m_wbyte({4'hB, STRAP, 1'b0}, ack); chk("R1 code mismatch", ack, 0);
      m_stop();

      // R8 R2 R9: random read across the array end, then no-acknowledge
      cur_req = "R8";
      m_start();
      m_wbyte({4'hA, STRAP, 1'b0}, ack);
      m_wbyte(8'h7E, ack);
      m_start();
      m_wbyte({4'hA, STRAP, 1'b1}, ack); chk("R2 read ack", ack, 1);
      m_rbyte(1, rb); chk("R8 byte 7E", rb, mem[7'h7E]);
      m_rbyte(1, rb); chk("R8 byte 7F", rb, mem[7'h7F]);
      m_rbyte(0, rb); chk("R8 wrapped byte 00", rb, mem[7'h00]);
      cur_req = "R9";
      chk("R9 released after nack", sda_oe, 0);
      m_wbyte(8'h00, ack); chk("R9 silent after nack", ack, 0);
      m_stop();
      chk("R9 pointer", rd_addr, 7'h01);

      // R7: aborts inside a byte
      cur_req = "R7";
      m_start();
      m_wbyte({4'hA, STRAP, 1'b0}, ack);
      m_wbyte(8'h20, ack);
      m_wbyte(8'h99, ack);
      m_bits(3, 8'hFF);
      m_stop();
      chk("R7 mid-byte stop no commit", wr_commit, 0);
      m_start();
      m_bits(4, {4'hA, STRAP, 1'b0});
      m_start();
      m_wbyte({4'hA, STRAP, 1'b1}, ack); chk("R7 restart after abort", ack, 1);
      m_rbyte(0, rb); chk("R8 read after abort", rb, mem[7'h21]);
      m_stop();

      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule